// File: doc/BRIEF.md
# Sector Protection Command Sequencer

This block sits behind the serial command front end of a paged flash device. It watches the stream of command bytes framed by an active-low select and picks out the protection commands. These commands share a fixed three-byte lead-in, and a fourth byte chooses the action. The block also watches a four-byte whole-array erase sequence. A recognised command acts only on the clock in which select returns high, and only if the frame held exactly the bytes that command needs.

The block keeps one protection byte and one lockdown flag for each sector, plus a global software enable. A hardware write-protect input overrides the software enable. Changes on that input are held back while the erase engine reports busy. For any page offered on the check port, the block answers at once whether a program or erase of that page may go ahead. A read port returns the stored protection byte and lockdown marker of any sector. A whole-array erase request is passed on as a one-cycle go pulse only when no sector would refuse it.

Top module: `sect_guard`

## Requirements
- R1: After reset every page is allowed, protection is off, every protection byte reads 00h, every lockdown marker reads 00h and `ce_go` is low.
- R2: A frame of exactly 3Dh 2Ah 7Fh A9h turns software protection on, and 3Dh 2Ah 7Fh 9Ah turns it off. With protection on, a sector whose protection byte is FFh is denied.
- R3: A frame of exactly 3Dh 2Ah 7Fh CFh sets every protection byte to FFh and arms the register for one program. It is ignored while the effective write-protect is high.
- R4: A frame of 3Dh 2Ah 7Fh FCh followed by exactly NSEC data bytes writes data byte k to sector k. This happens only when the register is armed, and the write disarms it. Without arming, or under effective write-protect, the frame changes nothing.
- R5: A frame of 3Dh 2Ah 7Fh 30h followed by exactly three address bytes (sent most significant first) locks the sector given by bits [22:17] of that 24-bit address. Those bits are the top six of the 13-bit page field at bits [22:10]. A locked sector reads FFh on `rd_lock`, is always denied, and no later command unlocks it.
- R6: Commands act only when `cs_n` rises. A frame with a wrong lead-in byte, too few bytes or extra bytes does nothing. Bytes offered while `cs_n` is high are dropped.
- R7: While the effective write-protect is high, a sector whose protection byte is FFh is denied even with software protection off.
- R8: The effective write-protect follows `wp` one cycle later, but holds its value on every cycle in which `erase_busy` is high.
- R9: The frame C7h 94h 80h 9Ah, exactly four bytes, raises `ce_go` for one cycle, starting one cycle after `cs_n` rises. It does so only if no sector is denied at that moment.
- R10: `chk_allow` is combinational in `chk_page`, and the sector is `chk_page[12:7]` (128 pages per sector).
- R11: With RD_REG = 0, `rd_prot` and `rd_lock` follow `rd_sector` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low command frame select |
| byte_valid | input | 1 | Strobe for one command byte |
| byte_data | input | 8 | Command byte |
| wp | input | 1 | Hardware write-protect, active high |
| erase_busy | input | 1 | High while the erase engine is running |
| chk_page | input | 13 | Page address to be judged |
| chk_allow | output | 1 | High when program or erase of `chk_page` is allowed |
| rd_sector | input | 6 | Sector picked for readout |
| rd_prot | output | 8 | Protection byte of `rd_sector` |
| rd_lock | output | 8 | Lockdown marker of `rd_sector`, FFh or 00h |
| ce_go | output | 1 | One-cycle go pulse for an allowed whole-array erase |

## Verification
The bench builds the block with its defaults: 64 sectors, a 13-bit page field, a 10-bit byte field and combinational readout. With these values the full 64-byte program frame can be exercised. Sector 63 can be reached with the don't-care address bit set, and the page edge between sectors 62 and 63 can be checked through the 7-bit in-sector page field. The combinational read port lets every protection byte be compared right after each command, with no extra wait cycle in the check.

// File: rtl/sect_guard_pkg.sv
package sect_guard_pkg;

   localparam int ADDR_W   = 24;
   localparam int HDR_LEN  = 4;
   localparam int ADDR_LEN = 3;

   localparam logic [7:0] PFX_A = 8'h3D;
   localparam logic [7:0] PFX_B = 8'h2A;
   localparam logic [7:0] PFX_C = 8'h7F;

   localparam logic [7:0] SEL_ON  = 8'hA9;
   localparam logic [7:0] SEL_OFF = 8'h9A;
   localparam logic [7:0] SEL_CLR = 8'hCF;
   localparam logic [7:0] SEL_PRG = 8'hFC;
   localparam logic [7:0] SEL_LCK = 8'h30;

   localparam logic [31:0] CHIP_SEQ = 32'hC794_809A;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_PROT_ON,
      CMD_PROT_OFF,
      CMD_REG_CLR,
      CMD_REG_PRG,
      CMD_LOCK,
      CMD_CHIP
   } sg_cmd_e;

endpackage

// File: rtl/sect_guard_frame.sv
module sect_guard_frame
   import sect_guard_pkg::*;
#(
   parameter int NSEC   = 64,
   parameter int PAGE_W = 13,
   parameter int BYTE_W = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs_n,
   input  logic                      byte_valid,
   input  logic [7:0]                byte_data,
   output sg_cmd_e                   cmd,
   output logic [$clog2(NSEC)-1:0]   lock_sect,
   output logic [NSEC*8-1:0]         stage
);

   localparam int SECT_W   = $clog2(NSEC);
   localparam int PROG_LEN = HDR_LEN + NSEC;
   localparam int LOCK_LEN = HDR_LEN + ADDR_LEN;
   localparam int MAX_LEN  = ((PROG_LEN > LOCK_LEN) ? PROG_LEN : LOCK_LEN) + 1;
   localparam int CNT_W    = $clog2(MAX_LEN + 1);
   localparam int SECT_LSB = BYTE_W + PAGE_W - SECT_W;
   localparam int TOP_BIT  = BYTE_W + PAGE_W;

   localparam logic [CNT_W-1:0] N_HDR = CNT_W'(HDR_LEN);
   localparam logic [CNT_W-1:0] N_PRG = CNT_W'(PROG_LEN);
   localparam logic [CNT_W-1:0] N_LCK = CNT_W'(LOCK_LEN);
   localparam logic [CNT_W-1:0] N_MAX = CNT_W'(MAX_LEN);

   if (SECT_W < 1 || (1 << SECT_W) != NSEC) begin : g_bad_nsec
      $error("sect_guard_frame: NSEC must be a power of two of at least 2");
   end
   if (PAGE_W <= SECT_W || BYTE_W < 1 || TOP_BIT >= ADDR_W) begin : g_bad_addr
      $error("sect_guard_frame: page and byte fields do not fit the address");
   end

   logic              cs_q;
   logic [CNT_W-1:0]  cnt;
   logic [31:0]       hdr;
   logic [ADDR_W-1:0] addr;
   logic              cs_rise;
   logic              unused_addr_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b1;
         cnt  <= '0;
         hdr  <= '0;
         addr <= '0;
      end else begin
         cs_q <= cs_n;
         if (cs_n) begin
            cnt <= '0;
         end else if (byte_valid) begin
            if (cnt < N_HDR)
               hdr <= {hdr[23:0], byte_data};
            else if (cnt < N_LCK)
               addr <= {addr[ADDR_W-9:0], byte_data};
            if (cnt != N_MAX)
               cnt <= cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage <= '0;
      end else if (!cs_n && byte_valid) begin
         for (int g = 0; g < NSEC; g++) begin
            if (cnt == CNT_W'(HDR_LEN + g))
               stage[g*8 +: 8] <= byte_data;
         end
      end
   end

   assign cs_rise = cs_n & ~cs_q;

   always_comb begin
      cmd = CMD_NONE;
      if (cs_rise) begin
         if (hdr[31:8] == {PFX_A, PFX_B, PFX_C}) begin
            case (hdr[7:0])
               SEL_ON:  if (cnt == N_HDR) cmd = CMD_PROT_ON;
               SEL_OFF: if (cnt == N_HDR) cmd = CMD_PROT_OFF;
               SEL_CLR: if (cnt == N_HDR) cmd = CMD_REG_CLR;
               SEL_PRG: if (cnt == N_PRG) cmd = CMD_REG_PRG;
               SEL_LCK: if (cnt == N_LCK) cmd = CMD_LOCK;
               default: cmd = CMD_NONE;
            endcase
         end else if (hdr == CHIP_SEQ && cnt == N_HDR) begin
            cmd = CMD_CHIP;
         end
      end
   end

   assign lock_sect        = addr[SECT_LSB +: SECT_W];
   assign unused_addr_bits = ^{addr[ADDR_W-1:TOP_BIT], addr[SECT_LSB-1:0]};

   // R6: a command is only ever issued on the cycle select returns high
   a_r6_cmd_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NONE) |-> (cs_n && !cs_q));

   // R6: no byte is counted while the frame is closed
   a_r6_count_closed: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (cnt == '0));

endmodule

// File: rtl/sect_guard_store.sv
module sect_guard_store
   import sect_guard_pkg::*;
#(
   parameter int NSEC   = 64,
   parameter int RD_REG = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  sg_cmd_e                   cmd,
   input  logic [$clog2(NSEC)-1:0]   lock_sect,
   input  logic [NSEC*8-1:0]         stage,
   input  logic                      wp_eff,
   input  logic [$clog2(NSEC)-1:0]   rd_sector,
   output logic [NSEC*8-1:0]         spr,
   output logic [NSEC-1:0]           lock,
   output logic                      prot_en,
   output logic [7:0]                rd_prot,
   output logic [7:0]                rd_lock
);

   localparam int SECT_W = $clog2(NSEC);

   if (RD_REG != 0 && RD_REG != 1) begin : g_bad_rd
      $error("sect_guard_store: RD_REG must be 0 or 1");
   end

   logic       armed;
   logic [7:0] rd_prot_d;
   logic [7:0] rd_lock_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spr     <= '0;
         lock    <= '0;
         prot_en <= 1'b0;
         armed   <= 1'b0;
      end else begin
         case (cmd)
            CMD_PROT_ON:  prot_en <= 1'b1;
            CMD_PROT_OFF: prot_en <= 1'b0;
            CMD_REG_CLR: begin
               if (!wp_eff) begin
                  spr   <= '1;
                  armed <= 1'b1;
               end
            end
            CMD_REG_PRG: begin
               if (!wp_eff && armed) begin
                  spr   <= stage;
                  armed <= 1'b0;
               end
            end
            CMD_LOCK: lock[lock_sect] <= 1'b1;
            default: ;
         endcase
      end
   end

   assign rd_prot_d = spr[{rd_sector, 3'b000} +: 8];
   assign rd_lock_d = {8{lock[rd_sector]}};

   if (RD_REG == 1) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_prot <= '0;
            rd_lock <= '0;
         end else begin
            rd_prot <= rd_prot_d;
            rd_lock <= rd_lock_d;
         end
      end
   end else begin : g_rd_comb
      assign rd_prot = rd_prot_d;
      assign rd_lock = rd_lock_d;
   end

   a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((lock & $past(lock)) == $past(lock)));

   a_r2_mode_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_en) |-> ($past(cmd) == CMD_PROT_ON || $past(cmd) == CMD_PROT_OFF));

   a_r4_spr_by_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spr) |-> (!$past(wp_eff) &&
                         ($past(cmd) == CMD_REG_CLR || $past(cmd) == CMD_REG_PRG)));

   a_r3_clear_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_REG_CLR && !wp_eff) |=> (spr == {NSEC*8{1'b1}}));

   a_r5_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_LOCK) |=> ($countones(lock) >= 1));

endmodule

// File: rtl/sect_guard_gate.sv
module sect_guard_gate
   import sect_guard_pkg::*;
#(
   parameter int NSEC   = 64,
   parameter int PAGE_W = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wp,
   input  logic                 erase_busy,
   input  sg_cmd_e              cmd,
   input  logic [NSEC*8-1:0]    spr,
   input  logic [NSEC-1:0]      lock,
   input  logic                 prot_en,
   input  logic [PAGE_W-1:0]    chk_page,
   output logic                 wp_eff,
   output logic                 chk_allow,
   output logic                 ce_go
);

   localparam int SECT_W = $clog2(NSEC);
   localparam int LOW_W  = PAGE_W - SECT_W;

   logic [NSEC-1:0]   deny;
   logic [SECT_W-1:0] chk_sect;
   logic              guard_on;
   logic              any_deny;
   logic              unused_page_low;

   assign guard_on = prot_en | wp_eff;

   for (genvar s = 0; s < NSEC; s++) begin : g_sect
      assign deny[s] = lock[s] | (guard_on & (spr[s*8 +: 8] == 8'hFF));
   end

   assign any_deny        = |deny;
   assign chk_sect        = chk_page[PAGE_W-1 -: SECT_W];
   assign unused_page_low = ^chk_page[LOW_W-1:0];
   assign chk_allow       = ~deny[chk_sect];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_eff <= 1'b0;
         ce_go  <= 1'b0;
      end else begin
         if (!erase_busy)
            wp_eff <= wp;
         ce_go <= (cmd == CMD_CHIP) && !any_deny;
      end
   end

   a_r8_wp_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      erase_busy |=> $stable(wp_eff));

   a_r8_wp_follow_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_busy |=> (wp_eff == $past(wp)));

   a_r5_lock_denies: assert property (@(posedge clk) disable iff (!rst_n)
      lock[chk_sect] |-> !chk_allow);

   a_r7_wp_denies: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_eff && spr[{chk_sect, 3'b000} +: 8] == 8'hFF) |-> !chk_allow);

   a_r9_ce_single: assert property (@(posedge clk) disable iff (!rst_n)
      ce_go |=> !ce_go);

   a_r9_ce_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      ce_go |-> ($past(cmd) == CMD_CHIP));

endmodule

// File: rtl/sect_guard.sv
module sect_guard
   import sect_guard_pkg::*;
#(
   parameter int NSEC   = 64,
   parameter int PAGE_W = 13,
   parameter int BYTE_W = 10,
   parameter int RD_REG = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     byte_valid,
   input  logic [7:0]               byte_data,
   input  logic                     wp,
   input  logic                     erase_busy,
   input  logic [PAGE_W-1:0]        chk_page,
   output logic                     chk_allow,
   input  logic [$clog2(NSEC)-1:0]  rd_sector,
   output logic [7:0]               rd_prot,
   output logic [7:0]               rd_lock,
   output logic                     ce_go
);

   localparam int SECT_W = $clog2(NSEC);

   sg_cmd_e             cmd;
   logic [SECT_W-1:0]   lock_sect;
   logic [NSEC*8-1:0]   stage;
   logic [NSEC*8-1:0]   spr;
   logic [NSEC-1:0]     lock;
   logic                prot_en;
   logic                wp_eff;

   sect_guard_frame #(
      .NSEC   (NSEC),
      .PAGE_W (PAGE_W),
      .BYTE_W (BYTE_W)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .byte_valid (byte_valid),
      .byte_data  (byte_data),
      .cmd        (cmd),
      .lock_sect  (lock_sect),
      .stage      (stage)
   );

   sect_guard_store #(
      .NSEC   (NSEC),
      .RD_REG (RD_REG)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .lock_sect (lock_sect),
      .stage     (stage),
      .wp_eff    (wp_eff),
      .rd_sector (rd_sector),
      .spr       (spr),
      .lock      (lock),
      .prot_en   (prot_en),
      .rd_prot   (rd_prot),
      .rd_lock   (rd_lock)
   );

   sect_guard_gate #(
      .NSEC   (NSEC),
      .PAGE_W (PAGE_W)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .wp         (wp),
      .erase_busy (erase_busy),
      .cmd        (cmd),
      .spr        (spr),
      .lock       (lock),
      .prot_en    (prot_en),
      .chk_page   (chk_page),
      .wp_eff     (wp_eff),
      .chk_allow  (chk_allow),
      .ce_go      (ce_go)
   );

endmodule

// File: tb/sect_guard_tb.sv
`timescale 1ns/1ps
module sect_guard_tb;

   localparam int NSEC   = 64;
   localparam int PAGE_W = 13;
   localparam int BYTE_W = 10;
   localparam int SECT_W = 6;
   localparam int LOW_W  = PAGE_W - SECT_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cs_n = 1'b1;
   logic              byte_valid = 1'b0;
   logic [7:0]        byte_data = '0;
   logic              wp = 1'b0;
   logic              erase_busy = 1'b0;
   logic [PAGE_W-1:0] chk_page = '0;
   logic              chk_allow;
   logic [SECT_W-1:0] rd_sector = '0;
   logic [7:0]        rd_prot;
   logic [7:0]        rd_lock;
   logic              ce_go;

   always #2.5 clk = ~clk;

   sect_guard #(
      .NSEC(NSEC), .PAGE_W(PAGE_W), .BYTE_W(BYTE_W), .RD_REG(0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
      .byte_data(byte_data), .wp(wp), .erase_busy(erase_busy),
      .chk_page(chk_page), .chk_allow(chk_allow), .rd_sector(rd_sector),
      .rd_prot(rd_prot), .rd_lock(rd_lock), .ce_go(ce_go)
   );

   // reference state
   logic [7:0] m_spr [NSEC];
   bit         m_lock [NSEC];
   bit         m_en, m_armed, m_wp_eff, m_ce;
   logic [7:0] fb [0:79];
   int         n_chk = 0;
   int         n_bad = 0;
   int         n_locks = 0;
   bit         done = 1'b0;

   function automatic bit exp_allow(input int s);
      return !(m_lock[s] || (m_spr[s] == 8'hFF && (m_en || m_wp_eff)));
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic probe(input int s, input int low, input string tag);
      chk_page  = {s[SECT_W-1:0], low[LOW_W-1:0]};
      rd_sector = s[SECT_W-1:0];
      #1;
      chk({tag, " R10 allow"}, {31'd0, chk_allow}, {31'd0, exp_allow(s)});
      chk({tag, " R11 rd_prot"}, {24'd0, rd_prot}, {24'd0, m_spr[s]});
      chk({tag, " R5 rd_lock"}, {24'd0, rd_lock}, m_lock[s] ? 32'hFF : 32'h0);
   endtask

   function automatic bit all_allowed();
      for (int s = 0; s < NSEC; s++)
         if (!exp_allow(s)) return 1'b0;
      return 1'b1;
   endfunction

   task automatic model_apply(input int n);
      logic [23:0] a;
      m_ce = 1'b0;
      if (fb[0] == 8'h3D && fb[1] == 8'h2A && fb[2] == 8'h7F && n >= 4) begin
         case (fb[3])
            8'hA9: if (n == 4) m_en = 1'b1;
            8'h9A: if (n == 4) m_en = 1'b0;
            8'hCF: if (n == 4 && !m_wp_eff) begin
               for (int s = 0; s < NSEC; s++) m_spr[s] = 8'hFF;
               m_armed = 1'b1;
            end
            8'hFC: if (n == 4 + NSEC && !m_wp_eff && m_armed) begin
               for (int s = 0; s < NSEC; s++) m_spr[s] = fb[4+s];
               m_armed = 1'b0;
            end
            8'h30: if (n == 7) begin
               a = {fb[4], fb[5], fb[6]};
               m_lock[a[22:17]] = 1'b1;
            end
            default: ;
         endcase
      end else if (n == 4 && fb[0] == 8'hC7 && fb[1] == 8'h94 && fb[2] == 8'h80 && fb[3] == 8'h9A) begin
         m_ce = all_allowed();
      end
   endtask

   task automatic send(input int n, input string tag);
      @(negedge clk) cs_n = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         byte_valid = 1'b1;
         byte_data  = fb[i];
      end
      @(negedge clk);
      byte_valid = 1'b0;
      cs_n = 1'b1;
      model_apply(n);
      @(negedge clk);
      chk({tag, " R9 ce_go"}, {31'd0, ce_go}, {31'd0, m_ce});
      @(negedge clk);
      chk({tag, " R9 ce_go one cycle"}, {31'd0, ce_go}, 32'd0);
   endtask

   task automatic set_hdr(input logic [7:0] sel);
      fb[0] = 8'h3D; fb[1] = 8'h2A; fb[2] = 8'h7F; fb[3] = sel;
   endtask

   task automatic set_chip();
      fb[0] = 8'hC7; fb[1] = 8'h94; fb[2] = 8'h80; fb[3] = 8'h9A;
   endtask

   task automatic set_lock(input int s, input int low, input bit dc);
      logic [23:0] a;
      a = {dc, s[SECT_W-1:0], low[LOW_W-1:0], 10'h155};
      set_hdr(8'h30);
      fb[4] = a[23:16]; fb[5] = a[15:8]; fb[6] = a[7:0];
   endtask

   task automatic set_wp(input bit v, input bit busy, input int s);
      @(negedge clk);
      wp = v;
      erase_busy = busy;
      if (busy) begin
         repeat (3) @(negedge clk);
         probe(s, 3, "R8 held while busy");
         erase_busy = 1'b0;
      end
      @(negedge clk);
      m_wp_eff = v;
      probe(s, 3, "R8 R7 after update");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed0;
      seed0 = $urandom(32'd4242);
      for (int s = 0; s < NSEC; s++) begin m_spr[s] = 8'h00; m_lock[s] = 1'b0; end
      m_en = 0; m_armed = 0; m_wp_eff = 0; m_ce = 0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      probe(0, 0, "R1 reset s0");
      probe(63, 127, "R1 reset s63");
      chk("R1 ce_go idle", {31'd0, ce_go}, 32'd0);

      // R4 program without prior erase is ignored
      set_hdr(8'hFC);
      for (int i = 0; i < NSEC; i++) fb[4+i] = 8'hFF;
      send(4 + NSEC, "R4 unarmed");
      probe(0, 1, "R4 unarmed");

      // R3 erase register, R2 protection off keeps all allowed
      set_hdr(8'hCF); send(4, "R3 clear");
      probe(0, 0, "R3 clear s0");
      probe(63, 9, "R3 clear s63");

      // R2 enable then disable
      set_hdr(8'hA9); send(4, "R2 enable");
      probe(5, 40, "R2 enabled");
      set_hdr(8'h9A); send(4, "R2 disable");
      probe(5, 40, "R2 disabled");

      // R4 program pattern: even FF, odd 00
      set_hdr(8'hFC);
      for (int i = 0; i < NSEC; i++) fb[4+i] = (i % 2 == 0) ? 8'hFF : 8'h00;
      send(4 + NSEC, "R4 program");
      probe(2, 0, "R4 even");
      probe(3, 0, "R4 odd");
      set_hdr(8'hFC);
      for (int i = 0; i < NSEC; i++) fb[4+i] = 8'h5A;
      send(4 + NSEC, "R4 second program");
      probe(3, 0, "R4 not rearmed");

      // R7 write-protect forces denial of FFh sectors; R3 clear ignored under WP
      set_wp(1'b1, 1'b0, 0);
      probe(1, 0, "R7 odd allowed");
      set_hdr(8'hCF); send(4, "R3 clear under wp");
      probe(1, 2, "R3 ignored under wp");
      set_wp(1'b0, 1'b0, 0);

      // R8 deferral while erase busy
      set_wp(1'b1, 1'b1, 4);
      set_wp(1'b0, 1'b1, 4);

      // R6 framing faults
      fb[0] = 8'h3D; fb[1] = 8'h2B; fb[2] = 8'h7F; fb[3] = 8'hA9;
      send(4, "R6 bad prefix");
      probe(0, 0, "R6 bad prefix");
      set_hdr(8'hA9); send(3, "R6 short");
      probe(0, 0, "R6 short");
      set_hdr(8'hA9); fb[4] = 8'h00; send(5, "R6 long");
      probe(0, 0, "R6 long");
      @(negedge clk); byte_valid = 1'b1; byte_data = 8'h3D;
      @(negedge clk); byte_valid = 1'b0;
      fb[0] = 8'h2A; fb[1] = 8'h7F; fb[2] = 8'hA9;
      send(3, "R6 bytes outside frame");
      probe(0, 0, "R6 bytes outside frame");

      // R9 chip erase allowed then refused
      set_chip(); send(4, "R9 chip allowed");
      set_hdr(8'hA9); send(4, "R2 enable again");
      set_chip(); send(4, "R9 chip refused");
      set_hdr(8'h9A); send(4, "R2 disable again");

      // R5 lockdown of sector 63 with the don't-care bit set
      set_lock(63, 5, 1'b1); send(7, "R5 lock"); n_locks++;
      probe(63, 0, "R5 locked s63");
      probe(62, 127, "R10 boundary s62");
      set_hdr(8'hCF); send(4, "R5 clear after lock");
      set_hdr(8'h9A); send(4, "R5 disable after lock");
      probe(63, 127, "R5 still locked");
      set_lock(10, 0, 1'b0); send(6, "R6 short lock");
      probe(10, 0, "R6 short lock");

      // randomized mix
      for (int it = 0; it < 250; it++) begin
         int op;
         op = int'($urandom % 10);
         case (op)
            0: begin set_hdr(8'hA9); send(4, "rand enable"); end
            1: begin set_hdr(8'h9A); send(4, "rand disable"); end
            2: begin set_hdr(8'hCF); send(4, "rand clear"); end
            3, 4: begin
               set_hdr(8'hFC);
               for (int i = 0; i < NSEC; i++)
                  fb[4+i] = ($urandom % 2 == 1) ? 8'hFF : 8'($urandom);
               send(4 + NSEC, "rand program");
            end
            5: begin
               if (n_locks < 8) begin
                  set_lock(int'($urandom % NSEC), int'($urandom), 1'($urandom));
                  send(7, "rand lock");
                  n_locks++;
               end else begin
                  set_hdr(8'h9A); send(4, "rand disable");
               end
            end
            6: begin set_chip(); send(4, "rand chip"); end
            7: begin
               int k;
               set_hdr(($urandom % 2 == 1) ? 8'hA9 : 8'hCF);
               k = int'($urandom % 3);
               if ($urandom % 2 == 1) begin
                  fb[k] = fb[k] ^ 8'h01;
                  send(4, "R6 rand corrupt");
               end else begin
                  fb[4] = 8'($urandom);
                  send((k == 0) ? 5 : 3, "R6 rand length");
               end
            end
            8: set_wp(1'($urandom), 1'($urandom), int'($urandom % NSEC));
            default: ;
         endcase
         for (int p = 0; p < 3; p++)
            probe(int'($urandom % NSEC), int'($urandom), "rand");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule